// File: doc/BRIEF.md
# PLL divider search engine

This block searches for the pre-divider N and the even feedback multiplier M of a PLL. A reference clock of `ref_hz` hertz is divided by N and multiplied by M. The block wants the pair whose output rate `ref_hz * M / N` lies closest to a target lane bit rate. It derives that target from the pixel clock, the pixel format and the number of lanes. The target is 25% above the raw pixel bandwidth, so the serial link keeps some headroom.

A single `start` pulse captures all inputs. The engine then steps through the candidate values of N one at a time, in increasing order. It rejects any candidate that breaks the multiplier or oscillator limits and keeps the one with the smallest absolute error. Every quotient comes from one shared shift-subtract divider, so the block contains no combinational divider. When the search ends, `done` pulses for one cycle. The result ports then hold the best N, M and output rate, or `err` is set and the result ports read zero. They keep those values until the next accepted `start`.

Top module: `pll_div_search`

## Requirements
- R1: The target rate is floor(floor(pclk_khz*1000 / lanes) * bpp / 8) * 10. bpp comes from `fmt`: 0 and 1 give 24, 2 gives 18, 3 gives 16.
- R2: If lanes is 0, or the target is 1,500,000,000 or more, the search ends with `err`=1. In that case `done` rises within 60 cycles of `start`.
- R3: N runs over ceil(ref_hz/40,000,000) up to floor(ref_hz/5,000,000). An empty range (including an upper bound of 0) yields no candidate.
- R4: For each N, M is floor(target*N/ref_hz). If that value is odd, it is raised by one. A reported `best_m` is always even.
- R5: A candidate whose M is below 6 or above 512 is rejected.
- R6: The candidate rate is floor(ref_hz*M/N). A candidate is rejected when this rate is below 80,000,000 or above 1,500,000,000. Both limits are inclusive.
- R7: A candidate replaces the stored best only when its absolute error from the target is strictly smaller. On equal error, the lowest N is kept.
- R8: If no candidate is accepted, `err`=1 and `best_n`, `best_m` and `best_hz` read 0.
- R9: `done` is high for exactly one cycle. Results and `err` hold until the next accepted `start`. A `start` pulse, and any change of input, while a search runs has no effect on that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; inputs are captured on this cycle |
| ref_hz | input | REF_W | Reference frequency in Hz |
| pclk_khz | input | PCLK_W | Pixel clock in kHz |
| lanes | input | LANE_W | Number of data lanes |
| fmt | input | 2 | Pixel format code (sets bits per pixel) |
| best_n | output | N_W | Chosen pre-divider |
| best_m | output | M_W | Chosen feedback multiplier |
| best_hz | output | REF_W | Output rate of the chosen pair in Hz |
| done | output | 1 | One-cycle end-of-search pulse |
| err | output | 1 | No valid pair, or target out of range |

## Verification
Faults inside the engine only become visible at the result ports, when `done` pulses, which is roughly a hundred cycles per N value after `start`. A stale best-error register or a wrong loop bound changes the chosen N or M only for targets where a later N would have won, or where one N lies on a range edge. For that reason the vectors include a tie across five N values, a rate sitting exactly on the upper oscillator limit, a reference that pushes the lower N bound above 1, and each rejection rule alone. A divider or target fault that produces a bad quotient shows up in every vector's M and rate at the first `done`.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

  localparam longint VCO_MAX_HZ = 64'd1500000000;
  localparam longint VCO_MIN_HZ = 64'd80000000;
  localparam longint PFD_MAX_HZ = 64'd40000000;
  localparam longint PFD_MIN_HZ = 64'd5000000;
  localparam int     MUL_MIN    = 6;
  localparam int     MUL_MAX    = 512;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TGT, ST_NLO, ST_NHI, ST_MDIV, ST_FDIV, ST_EVAL, ST_ADV, ST_FIN
  } srch_state_e;

  function automatic logic [4:0] bits_per_px(input logic [1:0] code);
    case (code)
      2'd2:    bits_per_px = 5'd18;
      2'd3:    bits_per_px = 5'd16;
      default: bits_per_px = 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/div_iter.sv
module div_iter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic         fin
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, rem_n, quo_q, quo_n, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, fin_q;
  logic [W:0]       shifted, trial;

  // one restoring step per cycle
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    rem_n   = trial[W] ? shifted[W-1:0] : trial[W-1:0];
    quo_n   = {quo_q[W-2:0], ~trial[W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (go) begin
      rem_q  <= '0;
      quo_q  <= dividend;
      dvs_q  <= divisor;
      cnt_q  <= CNT_W'(W);
      busy_q <= 1'b1;
      fin_q  <= 1'b0;
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign quo = quo_q;
  assign fin = fin_q;

  // R4: every quotient handed out leaves a remainder below its divisor
  assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/cand_check.sv
module cand_check
  import pll_srch_pkg::*;
#(
  parameter int W = 48
) (
  input  logic [W-1:0] m_raw,
  input  logic [W-1:0] cand_hz,
  input  logic [W-1:0] tgt_hz,
  input  logic [W-1:0] best_err,
  output logic [W-1:0] m_even,
  output logic         m_ok,
  output logic         better
);
  logic [W-1:0] err_abs;
  logic         f_ok;

  always_comb begin
    m_even  = m_raw + W'(m_raw[0]);
    m_ok    = (m_even >= W'(MUL_MIN)) && (m_even <= W'(MUL_MAX));
    f_ok    = (cand_hz >= W'(VCO_MIN_HZ)) && (cand_hz <= W'(VCO_MAX_HZ));
    err_abs = (tgt_hz >= cand_hz) ? (tgt_hz - cand_hz) : (cand_hz - tgt_hz);
    better  = f_ok && (err_abs < best_err);
  end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_srch_pkg::*;
#(
  parameter int FREQ_W = 48,
  parameter int REF_W  = 32,
  parameter int PCLK_W = 24,
  parameter int LANE_W = 3,
  parameter int N_W    = 8,
  parameter int M_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REF_W-1:0]  ref_hz,
  input  logic [PCLK_W-1:0] pclk_khz,
  input  logic [LANE_W-1:0] lanes,
  input  logic [1:0]        fmt,
  output logic [N_W-1:0]    best_n,
  output logic [M_W-1:0]    best_m,
  output logic [REF_W-1:0]  best_hz,
  output logic              done,
  output logic              err
);
  srch_state_e st_q, st_n;
  logic              issued_q, issued_n;
  logic [REF_W-1:0]  ref_q, ref_n;
  logic [PCLK_W-1:0] pclk_q, pclk_n;
  logic [LANE_W-1:0] lanes_q, lanes_n;
  logic [1:0]        fmt_q, fmt_n;
  logic [FREQ_W-1:0] tgt_q, tgt_n, f_q, f_n, berr_q, berr_n;
  logic [N_W-1:0]    nlo_q, nlo_n, nhi_q, nhi_n, n_q, n_n, bn_q, bn_n;
  logic [M_W-1:0]    m_q, m_n, bm_q, bm_n;
  logic [REF_W-1:0]  bf_q, bf_n;
  logic              found_q, found_n, done_q, done_n, err_q, err_n;

  logic [FREQ_W-1:0] dvd, dvs, quo, tgt_calc, m_even;
  logic              div_go, div_fin, m_ok, better;

  // divider operand select per state
  always_comb begin
    dvd = '0;
    dvs = FREQ_W'(1);
    case (st_q)
      ST_TGT:  begin dvd = FREQ_W'(pclk_q) * FREQ_W'(1000); dvs = FREQ_W'(lanes_q); end
      ST_NLO:  begin dvd = FREQ_W'(ref_q) + FREQ_W'(PFD_MAX_HZ - 1); dvs = FREQ_W'(PFD_MAX_HZ); end
      ST_NHI:  begin dvd = FREQ_W'(ref_q); dvs = FREQ_W'(PFD_MIN_HZ); end
      ST_MDIV: begin dvd = tgt_q * FREQ_W'(n_q); dvs = FREQ_W'(ref_q); end
      ST_FDIV: begin dvd = FREQ_W'(ref_q) * FREQ_W'(m_q); dvs = FREQ_W'(n_q); end
      default: ;
    endcase
  end

  assign div_go   = !issued_q && (st_q inside {ST_TGT, ST_NLO, ST_NHI, ST_MDIV, ST_FDIV});
  assign tgt_calc = ((quo * FREQ_W'(bits_per_px(fmt_q))) >> 3) * FREQ_W'(10);

  div_iter #(.W(FREQ_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(dvd), .divisor(dvs), .quo(quo), .fin(div_fin)
  );

  cand_check #(.W(FREQ_W)) u_cand (
    .m_raw(quo), .cand_hz(f_q), .tgt_hz(tgt_q), .best_err(berr_q),
    .m_even(m_even), .m_ok(m_ok), .better(better)
  );

  always_comb begin
    st_n = st_q;  issued_n = issued_q;
    ref_n = ref_q;  pclk_n = pclk_q;  lanes_n = lanes_q;  fmt_n = fmt_q;
    tgt_n = tgt_q;  f_n = f_q;  berr_n = berr_q;
    nlo_n = nlo_q;  nhi_n = nhi_q;  n_n = n_q;  m_n = m_q;
    bn_n = bn_q;  bm_n = bm_q;  bf_n = bf_q;  found_n = found_q;
    done_n = 1'b0;  err_n = err_q;
    if (div_go) issued_n = 1'b1;
    case (st_q)
      ST_IDLE: if (start) begin
        ref_n = ref_hz;  pclk_n = pclk_khz;  lanes_n = lanes;  fmt_n = fmt;
        bn_n = '0;  bm_n = '0;  bf_n = '0;  found_n = 1'b0;
        berr_n = FREQ_W'(VCO_MAX_HZ);
        issued_n = 1'b0;
        st_n = ST_TGT;
      end
      ST_TGT: if (div_fin) begin
        issued_n = 1'b0;
        tgt_n    = tgt_calc;
        st_n     = (lanes_q == '0 || tgt_calc >= FREQ_W'(VCO_MAX_HZ)) ? ST_FIN : ST_NLO;
      end
      ST_NLO: if (div_fin) begin
        issued_n = 1'b0;
        nlo_n    = quo[N_W-1:0];
        st_n     = ST_NHI;
      end
      ST_NHI: if (div_fin) begin
        issued_n = 1'b0;
        nhi_n    = quo[N_W-1:0];
        n_n      = nlo_q;
        st_n     = (quo[N_W-1:0] == '0 || nlo_q > quo[N_W-1:0]) ? ST_FIN : ST_MDIV;
      end
      ST_MDIV: if (div_fin) begin
        issued_n = 1'b0;
        m_n      = m_even[M_W-1:0];
        st_n     = m_ok ? ST_FDIV : ST_ADV;
      end
      ST_FDIV: if (div_fin) begin
        issued_n = 1'b0;
        f_n      = quo;
        st_n     = ST_EVAL;
      end
      ST_EVAL: begin
        if (better) begin
          berr_n  = (tgt_q >= f_q) ? (tgt_q - f_q) : (f_q - tgt_q);
          bn_n    = n_q;  bm_n = m_q;  bf_n = f_q[REF_W-1:0];
          found_n = 1'b1;
        end
        st_n = ST_ADV;
      end
      ST_ADV: begin
        if (n_q == nhi_q) st_n = ST_FIN;
        else begin
          n_n  = n_q + 1'b1;
          st_n = ST_MDIV;
        end
      end
      ST_FIN: begin
        done_n = 1'b1;
        err_n  = !found_q;
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  issued_q <= 1'b0;
      ref_q <= '0;  pclk_q <= '0;  lanes_q <= '0;  fmt_q <= '0;
      tgt_q <= '0;  f_q <= '0;  berr_q <= '0;
      nlo_q <= '0;  nhi_q <= '0;  n_q <= '0;  m_q <= '0;
      bn_q <= '0;  bm_q <= '0;  bf_q <= '0;  found_q <= 1'b0;
      done_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      st_q <= st_n;  issued_q <= issued_n;
      ref_q <= ref_n;  pclk_q <= pclk_n;  lanes_q <= lanes_n;  fmt_q <= fmt_n;
      tgt_q <= tgt_n;  f_q <= f_n;  berr_q <= berr_n;
      nlo_q <= nlo_n;  nhi_q <= nhi_n;  n_q <= n_n;  m_q <= m_n;
      bn_q <= bn_n;  bm_q <= bm_n;  bf_q <= bf_n;  found_q <= found_n;
      done_q <= done_n;  err_q <= err_n;
    end
  end

  assign best_n  = bn_q;
  assign best_m  = bm_q;
  assign best_hz = bf_q;
  assign done    = done_q;
  assign err     = err_q;

  // R9: end-of-search flag lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: the error flag only moves together with the end-of-search pulse
  assert_err_moves_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err) |-> done);
  // R3: the divider step under test stays inside the computed N range
  assert_n_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MDIV) |-> (n_q >= nlo_q && n_q <= nhi_q));
  // R4: a reported multiplier is even
  assert_m_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (best_m[0] == 1'b0));
  // R5: a reported multiplier lies in its legal range
  assert_m_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (best_m >= M_W'(MUL_MIN) && best_m <= M_W'(MUL_MAX)));
  // R6: a reported rate lies inside the oscillator window
  assert_rate_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (FREQ_W'(best_hz) >= FREQ_W'(VCO_MIN_HZ) &&
                        FREQ_W'(best_hz) <= FREQ_W'(VCO_MAX_HZ)));

endmodule

// File: tb/test_pll_div_search.sv
module test_pll_div_search;

  typedef struct packed {
    logic [31:0] fref;
    logic [23:0] pclk;
    logic [2:0]  lanes;
    logic [1:0]  fmt;
    logic        xerr;
    logic [7:0]  xn;
    logic [9:0]  xm;
    logic [31:0] xf;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'd24000000,  24'd148500, 3'd4, 2'd0, 1'b0, 8'd4,  10'd186, 32'd1116000000},
    '{32'd24000000,  24'd74250,  3'd4, 2'd2, 1'b0, 8'd3,  10'd52,  32'd416000000},
    '{32'd27000000,  24'd65000,  3'd2, 2'd1, 1'b0, 8'd1,  10'd36,  32'd972000000},
    '{32'd24000000,  24'd49999,  3'd1, 2'd0, 1'b0, 8'd4,  10'd250, 32'd1500000000},
    '{32'd100000000, 24'd148500, 3'd4, 2'd0, 1'b0, 8'd7,  10'd78,  32'd1114285714},
    '{32'd24000000,  24'd148500, 3'd4, 2'd3, 1'b0, 8'd2,  10'd62,  32'd744000000},
    '{32'd24000000,  24'd50000,  3'd1, 2'd0, 1'b1, 8'd0,  10'd0,   32'd0},
    '{32'd24000000,  24'd148500, 3'd0, 2'd0, 1'b1, 8'd0,  10'd0,   32'd0},
    '{32'd24000000,  24'd1000,   3'd4, 2'd3, 1'b1, 8'd0,  10'd0,   32'd0},
    '{32'd24000000,  24'd10000,  3'd4, 2'd3, 1'b1, 8'd0,  10'd0,   32'd0},
    '{32'd4000000,   24'd148500, 3'd4, 2'd0, 1'b1, 8'd0,  10'd0,   32'd0}
  };

  logic        clk, rst_n, start;
  logic [31:0] ref_hz;
  logic [23:0] pclk_khz;
  logic [2:0]  lanes;
  logic [1:0]  fmt;
  logic [7:0]  best_n;
  logic [9:0]  best_m;
  logic [31:0] best_hz;
  logic        done, err;

  int checks = 0;
  int fails  = 0;

  pll_div_search i_pll_div_search (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz),
    .pclk_khz(pclk_khz), .lanes(lanes), .fmt(fmt),
    .best_n(best_n), .best_m(best_m), .best_hz(best_hz),
    .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    ref_hz = v.fref; pclk_khz = v.pclk; lanes = v.lanes; fmt = v.fmt;
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done; a timeout is the watchdog and counts as a failure
  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
  endtask

  task automatic check_result(input vec_t v, input int idx);
    check($sformatf("R2/R8 err vec%0d", idx), err, v.xerr);
    check($sformatf("R3/R7 n vec%0d", idx), best_n, v.xn);
    check($sformatf("R4/R5 m vec%0d", idx), best_m, v.xm);
    check($sformatf("R1/R6 rate vec%0d", idx), best_hz, v.xf);
  endtask

  initial begin
    int cyc;
    start = 1'b0; rst_n = 1'b0;
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset done", done, 0);
    check("reset err", err, 0);
    check("reset n", best_n, 0);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      wait_done(cyc);
      check_result(VECS[i], i);
      if (i == 6) check("R2 latency within 60", (cyc <= 60) ? 1 : 0, 1);
      @(negedge clk);
      check("R9 done single cycle", done, 0);
    end

    // R9: start and input changes during a search are ignored
    launch(VECS[0]);
    repeat (10) @(negedge clk);
    apply(VECS[6]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    check_result(VECS[0], 100);
    // R9: results hold after the pulse while inputs move
    apply(VECS[1]);
    repeat (5) @(negedge clk);
    check("R9 hold n", best_n, VECS[0].xn);
    check("R9 hold m", best_m, VECS[0].xm);
    check("R9 hold rate", best_hz, VECS[0].xf);
    check("R9 hold done low", done, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule